// File: doc/BRIEF.md
# Distributed Arithmetic FIR Filter

This block is a fixed-coefficient low-pass FIR filter that forms each output sample without any multiplier. An accepted sample enters a tap delay line. The filter then walks through the bit positions of the stored samples, starting at the most significant bit. At each step, one bit taken from every tap forms an address. That address reads small tables that hold precomputed sums of coefficients, and a shift-accumulator merges the table outputs into the full-precision inner product. The cycle that covers the sign bit subtracts its table value instead of adding it.

The taps are split into groups of `GROUP`, and each group has its own table of 2^GROUP entries. The tables are built at elaboration from the `COEFS` parameter, and an adder tree joins the group outputs. `BITS_PER_CLK` copies the tables so that several bit positions are handled per clock. `PIPE_EN` adds registers after the lookup and after the adder tree to shorten the critical path. The final sum is rounded and saturated back to the sample format (`DATA_W` bits, `FRAC_W` fractional bits). Coefficients use the same format as the samples.

Upstream logic offers a sample with `in_valid` and may present it only while `in_ready` is high. `out_valid` pulses once for each result.

Top module: `da_fir`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. Every tap of the delay line holds zero, so the first result after reset depends only on the samples accepted since reset.
- R2: A single sample of value 2^FRAC_W (1.0), followed by zero samples, produces the coefficients as successive results in tap order: tap 0 first, then tap 1, and so on.
- R3: A result equals round(sum over k of COEF[k]·x[n−k] / 2^FRAC_W). Here samples and coefficients are two's-complement, x[n] is the newest accepted sample and sits at tap 0, and COEF[k] occupies `COEFS[k*COEF_W +: COEF_W]`.
- R4: `out_valid` is high for exactly one cycle. It rises DATA_W/BITS_PER_CLK + 1 + 2·PIPE_EN clock edges after the edge that accepted the sample.
- R5: `in_ready` falls on the accepting edge and stays low until it rises together with `out_valid`. Any `in_valid` seen while `in_ready` is low is ignored, and the delay line is left unchanged.
- R6: A result above 2^(DATA_W−1)−1 is driven as 2^(DATA_W−1)−1.
- R7: A result below −2^(DATA_W−1) is driven as −2^(DATA_W−1).
- R8: A result that falls exactly halfway between two output codes rounds toward plus infinity. For example, 48.5 becomes 49 and −48.5 becomes −48.
- R9: With BITS_PER_CLK = 2, results are bit-identical to R3 while using half the accumulation steps.
- R10: With PIPE_EN = 0, the latency in R4 is two cycles shorter and results are unchanged.
- R11: `out_data` holds its value between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered on `in_data` |
| in_data | input | DATA_W | Two's-complement sample, FRAC_W fractional bits |
| in_ready | output | 1 | The filter can take a sample this cycle |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | DATA_W | Rounded, saturated result in the sample format |

## Verification
The assertions check the handshake and timing rules on every cycle. These are the one-cycle width of the result strobe, the exact distance from acceptance to that strobe (measured with a counter), `in_ready` falling after an accept and rising with the strobe, and `out_data` staying stable between strobes. Only the bench scenarios can show the arithmetic itself: the coefficient order reproduced by an impulse, the sign-bit subtraction under negative samples, half-up rounding at exact midpoints, saturation at both rails, that samples offered while busy are discarded, and that the two-bits-per-clock, unpipelined variant gives the same numbers as the one-bit pipelined one.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  // Control token that travels alongside each bit slice through the pipeline
  typedef struct packed {
    logic vld;    // slice carries real data
    logic first;  // slice contains the sign bit (negative weight)
    logic last;   // final slice of the current sample
  } slice_tag_t;

  // Width needed to hold a sum of `terms` signed values of width coef_w
  function automatic int sum_width(input int coef_w, input int terms);
    return coef_w + $clog2(terms) + 1;
  endfunction

endpackage

// File: rtl/da_group_rom.sv
module da_group_rom #(
  parameter int                      GROUP  = 4,
  parameter int                      COEF_W = 16,
  parameter int                      TBL_W  = 19,
  parameter logic [GROUP*COEF_W-1:0] GCOEF  = '0
) (
  input  logic [GROUP-1:0]          addr,
  output logic signed [TBL_W-1:0]   data
);

  localparam int DEPTH = 1 << GROUP;

  // Entry a is the sum of the coefficients whose bit is set in a
  function automatic logic signed [TBL_W-1:0] entry(input int a);
    logic signed [TBL_W-1:0] s;
    s = '0;
    for (int i = 0; i < GROUP; i++) begin
      if (a[i]) s += TBL_W'(signed'(GCOEF[i*COEF_W +: COEF_W]));
    end
    return s;
  endfunction

  logic signed [TBL_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign rom[a] = entry(a);
  end

  assign data = rom[addr];

endmodule

// File: rtl/da_lane_sum.sv
module da_lane_sum #(
  parameter int                      TAPS    = 16,
  parameter int                      GROUP   = 4,
  parameter int                      COEF_W  = 16,
  parameter int                      TBL_W   = 19,
  parameter int                      LANE_W  = 21,
  parameter bit                      PIPE_EN = 1'b1,
  parameter logic [TAPS*COEF_W-1:0]  COEFS   = '0
) (
  input  logic                      clk,
  input  logic [TAPS-1:0]           addr,
  output logic signed [LANE_W-1:0]  sum
);

  localparam int NGRP = TAPS / GROUP;

  logic signed [TBL_W-1:0]  grp_raw [NGRP];
  logic signed [TBL_W-1:0]  grp_q   [NGRP];
  logic signed [LANE_W-1:0] tree;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    da_group_rom #(
      .GROUP  (GROUP),
      .COEF_W (COEF_W),
      .TBL_W  (TBL_W),
      .GCOEF  (COEFS[g*GROUP*COEF_W +: GROUP*COEF_W])
    ) u_rom (
      .addr (addr[g*GROUP +: GROUP]),
      .data (grp_raw[g])
    );
  end

  // Optional register between lookup and adder tree
  if (PIPE_EN) begin : g_lut_reg
    always_ff @(posedge clk) begin
      for (int g = 0; g < NGRP; g++) grp_q[g] <= grp_raw[g];
    end
  end else begin : g_lut_wire
    always_comb begin
      for (int g = 0; g < NGRP; g++) grp_q[g] = grp_raw[g];
    end
  end

  always_comb begin
    tree = '0;
    for (int g = 0; g < NGRP; g++) tree += LANE_W'(grp_q[g]);
  end

  // Optional register between adder tree and accumulator
  if (PIPE_EN) begin : g_tree_reg
    always_ff @(posedge clk) sum <= tree;
  end else begin : g_tree_wire
    assign sum = tree;
  end

endmodule

// File: rtl/da_tap_line.sv
module da_tap_line #(
  parameter int DATA_W       = 16,
  parameter int TAPS         = 16,
  parameter int BITS_PER_CLK = 1,
  parameter int CNT_W        = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [DATA_W-1:0]            din,
  input  logic [CNT_W-1:0]             idx,
  output logic [BITS_PER_CLK*TAPS-1:0] slices
);

  logic [DATA_W-1:0] taps [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) taps[k] <= '0;
    end else if (load) begin
      taps[0] <= din;
      for (int k = 1; k < TAPS; k++) taps[k] <= taps[k-1];
    end
  end

  // Lane j carries bit (DATA_W-1 - BITS_PER_CLK*idx - j) of every tap
  always_comb begin
    int pos;
    for (int j = 0; j < BITS_PER_CLK; j++) begin
      pos = DATA_W - 1 - BITS_PER_CLK * int'(idx) - j;
      for (int k = 0; k < TAPS; k++) begin
        slices[j*TAPS + k] = taps[k][pos];
      end
    end
  end

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc
  import da_fir_pkg::*;
#(
  parameter int BITS_PER_CLK = 1,
  parameter int LANE_W       = 21,
  parameter int ACC_W        = 37,
  parameter int DATA_W       = 16,
  parameter int FRAC_W       = 14
) (
  input  logic                           clk,
  input  logic                           rst,
  input  slice_tag_t                     tag,
  input  logic [BITS_PER_CLK*LANE_W-1:0] lanes,
  output logic [DATA_W-1:0]              out_data,
  output logic                           out_valid,
  output logic                           fin
);

  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] contrib;
  logic signed [ACC_W-1:0] lane_ext;
  logic signed [ACC_W-1:0] rnd;
  logic [DATA_W-1:0]       sat;

  // Weight the lanes of this step; the sign-bit lane counts negative
  always_comb begin
    contrib  = '0;
    lane_ext = '0;
    for (int j = 0; j < BITS_PER_CLK; j++) begin
      lane_ext = ACC_W'(signed'(lanes[j*LANE_W +: LANE_W]));
      lane_ext = lane_ext <<< (BITS_PER_CLK - 1 - j);
      if (tag.first && j == 0) contrib -= lane_ext;
      else                     contrib += lane_ext;
    end
  end

  // Round half up, then clamp to the output range
  always_comb begin
    rnd = (acc + HALF) >>> FRAC_W;
    if (rnd > MAXV)      sat = MAXV[DATA_W-1:0];
    else if (rnd < MINV) sat = MINV[DATA_W-1:0];
    else                 sat = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      fin       <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      fin       <= tag.vld & tag.last;
      out_valid <= fin;
      if (tag.vld) acc <= tag.first ? contrib : (acc <<< BITS_PER_CLK) + contrib;
      if (fin)     out_data <= sat;
    end
  end

endmodule

// File: rtl/da_fir.sv
module da_fir
  import da_fir_pkg::*;
#(
  parameter int                      DATA_W       = 16,
  parameter int                      FRAC_W       = 14,
  parameter int                      TAPS         = 16,
  parameter int                      GROUP        = 4,
  parameter int                      BITS_PER_CLK = 1,
  parameter bit                      PIPE_EN      = 1'b1,
  parameter logic [TAPS*DATA_W-1:0]  COEFS        = 256'hFF88_FECA_FEE8_019A_05DC_0AF0_0F3C_1130_1130_0F3C_0AF0_05DC_019A_FEE8_FECA_FF88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int COEF_W = DATA_W;
  localparam int STEPS  = DATA_W / BITS_PER_CLK;
  localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int TBL_W  = sum_width(COEF_W, GROUP);
  localparam int LANE_W = sum_width(COEF_W, TAPS);
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS) + 1;

  logic                           busy;
  logic                           issuing;
  logic [CNT_W-1:0]               idx;
  logic                           accept;
  logic                           fin;
  logic [BITS_PER_CLK*TAPS-1:0]   slices;
  logic [BITS_PER_CLK*LANE_W-1:0] lanes;
  slice_tag_t                     tag_issue;
  slice_tag_t                     tag_acc;

  assign accept   = in_valid & ~busy;
  assign in_ready = ~busy;

  // Step sequencer: one slice per clock from the sign bit downwards
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      idx     <= '0;
    end else begin
      if (fin) busy <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        issuing <= 1'b1;
        idx     <= '0;
      end else if (issuing) begin
        if (idx == CNT_W'(STEPS - 1)) begin
          issuing <= 1'b0;
          idx     <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    tag_issue.vld   = issuing;
    tag_issue.first = (idx == '0);
    tag_issue.last  = (idx == CNT_W'(STEPS - 1));
  end

  // Tag follows the two data register stages when pipelining is on
  if (PIPE_EN) begin : g_tag_pipe
    slice_tag_t tag_d1;
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_d1  <= '0;
        tag_acc <= '0;
      end else begin
        tag_d1  <= tag_issue;
        tag_acc <= tag_d1;
      end
    end
  end else begin : g_tag_wire
    assign tag_acc = tag_issue;
  end

  da_tap_line #(
    .DATA_W       (DATA_W),
    .TAPS         (TAPS),
    .BITS_PER_CLK (BITS_PER_CLK),
    .CNT_W        (CNT_W)
  ) u_taps (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .din    (in_data),
    .idx    (idx),
    .slices (slices)
  );

  for (genvar j = 0; j < BITS_PER_CLK; j++) begin : g_lane
    da_lane_sum #(
      .TAPS    (TAPS),
      .GROUP   (GROUP),
      .COEF_W  (COEF_W),
      .TBL_W   (TBL_W),
      .LANE_W  (LANE_W),
      .PIPE_EN (PIPE_EN),
      .COEFS   (COEFS)
    ) u_lane (
      .clk  (clk),
      .addr (slices[j*TAPS +: TAPS]),
      .sum  (lanes[j*LANE_W +: LANE_W])
    );
  end

  da_shift_acc #(
    .BITS_PER_CLK (BITS_PER_CLK),
    .LANE_W       (LANE_W),
    .ACC_W        (ACC_W),
    .DATA_W       (DATA_W),
    .FRAC_W       (FRAC_W)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .tag       (tag_acc),
    .lanes     (lanes),
    .out_data  (out_data),
    .out_valid (out_valid),
    .fin       (fin)
  );

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int DATA_W       = 16,
  parameter int BITS_PER_CLK = 1,
  parameter bit PIPE_EN      = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  localparam int LAT = DATA_W / BITS_PER_CLK + 1 + 2 * int'(PIPE_EN);

  // Edges seen since the accepting edge, counting that edge as 1
  logic [15:0] since;

  always_ff @(posedge clk) begin
    if (rst)                         since <= '0;
    else if (in_valid && in_ready)   since <= 16'd1;
    else if (out_valid)              since <= '0;
    else if (since != '0)            since <= since + 16'd1;
  end

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R4
  result_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since == 16'(LAT + 1)));

  // R5
  ready_with_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  // R5
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

endmodule

bind da_fir da_fir_chk #(
  .DATA_W       (DATA_W),
  .BITS_PER_CLK (BITS_PER_CLK),
  .PIPE_EN      (PIPE_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_da_fir.sv
module sim_da_fir;

  localparam int DW   = 16;
  localparam int FW   = 14;
  localparam int NT   = 16;
  localparam int CO [NT] = '{97, -310, -280, 410, 1500, 2800, 3900, 4400,
                             4380, 3900, 2800, 1500, 410, -280, -310, -120};
  localparam int LAT [2] = '{19, 9};   // u0: 1 bit/clk piped, u1: 2 bits/clk unpiped

  function automatic logic [NT*DW-1:0] pack_coefs();
    logic [NT*DW-1:0] v;
    for (int k = 0; k < NT; k++) v[k*DW +: DW] = DW'(CO[k]);
    return v;
  endfunction

  localparam logic [NT*DW-1:0] CFLAT = pack_coefs();

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          rdy0, ov0, rdy1, ov1;
  logic [DW-1:0] od0, od1;

  always #2 clk = ~clk;

  da_fir #(.DATA_W(DW), .FRAC_W(FW), .TAPS(NT), .GROUP(4), .BITS_PER_CLK(1),
           .PIPE_EN(1'b1), .COEFS(CFLAT)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(rdy0), .out_valid(ov0), .out_data(od0));

  da_fir #(.DATA_W(DW), .FRAC_W(FW), .TAPS(NT), .GROUP(4), .BITS_PER_CLK(2),
           .PIPE_EN(1'b0), .COEFS(CFLAT)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(rdy1), .out_valid(ov1), .out_data(od1));

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference, one per instance ----------------
  bit     started = 1'b0;
  bit     m_busy  [2];
  int     m_cnt   [2];
  bit     m_valid [2];
  longint m_data  [2];
  longint m_pend  [2];
  longint hist    [2][NT];

  function automatic longint filt(input int inst);
    longint y, r;
    y = 0;
    for (int k = 0; k < NT; k++) y += longint'(CO[k]) * hist[inst][k];
    r = (y + (64'sd1 <<< (FW - 1))) >>> FW;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_busy[i] = 0; m_cnt[i] = 0; m_valid[i] = 0; m_data[i] = 0; m_pend[i] = 0;
        for (int k = 0; k < NT; k++) hist[i][k] = 0;
      end else begin
        m_valid[i] = 0;
        if (m_busy[i]) begin
          m_cnt[i]++;
          if (m_cnt[i] == LAT[i]) begin
            m_valid[i] = 1; m_busy[i] = 0; m_data[i] = m_pend[i];
          end
        end else if (in_valid) begin
          for (int k = NT - 1; k > 0; k--) hist[i][k] = hist[i][k-1];
          hist[i][0] = longint'($signed(in_data));
          m_pend[i] = filt(i);
          m_busy[i] = 1; m_cnt[i] = 0;
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check(ov0 == m_valid[0], "R4 u0 out_valid", longint'(ov0), longint'(m_valid[0]));
      check(rdy0 == !m_busy[0], "R5 u0 in_ready", longint'(rdy0), longint'(!m_busy[0]));
      check(longint'($signed(od0)) == m_data[0], ov0 ? "R3 u0 out_data" : "R11 u0 hold",
            longint'($signed(od0)), m_data[0]);
      check(ov1 == m_valid[1], "R10 u1 out_valid", longint'(ov1), longint'(m_valid[1]));
      check(rdy1 == !m_busy[1], "R5 u1 in_ready", longint'(rdy1), longint'(!m_busy[1]));
      check(longint'($signed(od1)) == m_data[1], ov1 ? "R9 u1 out_data" : "R11 u1 hold",
            longint'($signed(od1)), m_data[1]);
    end
  end

  // ---------------- stimulus helpers ----------------
  longint r0, r1;
  bit     got1;

  // Offer one sample when u0 is ready; record results and strobe distances
  task automatic send(input int v);
    bit a1;
    int c0, c1;
    while (!rdy0) @(negedge clk);
    a1 = rdy1;
    in_valid = 1'b1;
    in_data  = DW'(v);
    @(negedge clk);
    in_valid = 1'b0;
    c0 = -1; c1 = -1; got1 = 0;
    for (int c = 1; c <= 40; c++) begin
      if (a1 && ov1 && c1 < 0) begin c1 = c; r1 = longint'($signed(od1)); got1 = 1; end
      if (ov0) begin c0 = c; r0 = longint'($signed(od0)); break; end
      @(negedge clk);
    end
    // strobe seen at negedge LAT+1 after the accepting edge's negedge count
    check(c0 == LAT[0] + 1, "R4 u0 latency", c0, LAT[0] + 1);
    if (a1) check(c1 == LAT[1] + 1, "R10 u1 latency", c1, LAT[1] + 1);
  endtask

  task automatic flush();
    for (int i = 0; i < NT; i++) send(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(ov0 == 0, "R1 out_valid in reset", longint'(ov0), 0);
    check(od0 == 0, "R1 out_data in reset", longint'(od0), 0);
    check(rdy0 == 1, "R1 in_ready in reset", longint'(rdy0), 1);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R8: first sample after reset alone drives the result; 97*0.5 = 48.5 -> 49
    send(8192);
    check(r0 == 49, "R8 half-up positive (R1 clear taps)", r0, 49);
    if (got1) check(r1 == 49, "R9 two-bit mode", r1, 49);
    send(0);
    check(r0 == -155, "R3 second tap", r0, -155);
    flush();
    // R8: 97*(-0.5) = -48.5 -> -48
    send(-8192);
    check(r0 == -48, "R8 half-up negative", r0, -48);
    flush();

    // R2: impulse of 1.0 replays coefficients in tap order
    send(16384);
    check(r0 == CO[0], "R2 impulse tap 0", r0, CO[0]);
    for (int k = 1; k < NT; k++) begin
      send(0);
      check(r0 == CO[k], "R2 impulse tap", r0, CO[k]);
      if (got1) check(r1 == CO[k], "R9 impulse tap", r1, CO[k]);
    end

    // R5: offers while busy are ignored and in_ready stays low
    while (!rdy0) @(negedge clk);
    in_valid = 1'b1; in_data = DW'(1000);
    @(negedge clk);
    in_data = DW'(32767);
    for (int i = 0; i < 10; i++) begin
      check(rdy0 == 0, "R5 in_ready low while busy", longint'(rdy0), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (!ov0) @(negedge clk);
    // 97*1000/16384 = 5.92 -> 6; a taken 32767 would change it
    check(longint'($signed(od0)) == 6, "R5 busy offer ignored", longint'($signed(od0)), 6);
    @(negedge clk);

    // R3: mixed-sign random stream, checked by the reference every cycle
    for (int i = 0; i < 30; i++) send(int'($signed(16'($urandom_range(0, 65535)))));

    // R6: full-scale positive saturates
    for (int i = 0; i < NT; i++) send(32767);
    check(r0 == 32767, "R6 positive saturation", r0, 32767);
    // R7: full-scale negative saturates
    for (int i = 0; i < NT; i++) send(-32768);
    check(r0 == -32768, "R7 negative saturation", r0, -32768);

    repeat (25) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule